// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

The block divides its clock by a programmable ratio n, anywhere from 3 to 15 999, and marks each period with a single-cycle high pulse on `divOut`. It is a synchronous mixed-radix down counter with three parts. The lowest stage has a selectable radix of 2, 4, 5, 8 or 10. Above it sit three cascaded BCD decades. The top stage has thousands weight and is built from whatever bits the lowest stage leaves unused. A 16-bit preset word, `jam`, supplies the starting value of every stage. When the count reaches its end, the stages reload from `jam` and the pulse fires.

The mode input selects the radix of the lowest stage. It also selects a fixed divide-by-10 000 mode, which ignores `jam`, and a master-preset state, which holds the counter at its preset. The period works out to n = radix × (1000·top + 100·d4 + 10·d3 + d2) + d1. When `latchEn` is high the block acts as a timer: once a pulse has occurred, the output stays high until `latchEn` drops, and the counter keeps running underneath.

Top module: `prog_divider`

## Requirements
- R1: `modeSel` = {Ka,Kb,Kc} decodes as follows: 111 gives radix 2, 011 gives radix 4, 101 gives radix 5, 001 gives radix 8, 110 gives radix 10, 000 gives fixed divide-by-10 000, and 010 or 100 gives master preset. The bits jam[15:12], jam[11:8] and jam[7:4] preset decades d4, d3 and d2. The low nibble is split by radix. Radix 2: d1=jam[0] and top=jam[3:1]. Radix 4: d1=jam[1:0] and top=jam[3:2]. Radix 5 or 8: d1=jam[2:0] and top=jam[3]. Radix 10: d1=jam[3:0] and there is no top stage.
- R2: With `latchEn` low, the spacing between output pulses is n = radix × (1000·top + 100·d4 + 10·d3 + d2) + d1 clock cycles.
- R3: With `latchEn` low, each output pulse is high for exactly one clock cycle.
- R4: After synchronous reset is released, the first clock edge loads `jam`, and the first pulse goes high after edge n+1.
- R5: A d1 value above radix−1 behaves as radix−1, and a decade nibble above 9 behaves as 9.
- R6: While `latchEn` is high, the output stays high from the first pulse onward. Once `latchEn` goes low, the output falls at the next edge. Pulse timing is unaffected by the latch.
- R7: In master preset the output is low at every edge. The counter holds the preset value, so the first pulse after leaving this state comes n edges after the last master-preset edge.
- R8: In the fixed mode the pulse period is 10 000 cycles whatever `jam` holds, including when `jam` changes mid-run.
- R9: Synchronous active-high reset drives the output low at the next edge, even when the output is latched high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 3 | Mode code {Ka,Kb,Kc} |
| jam | input | 16 | Preset word for all stages |
| latchEn | input | 1 | Timer latch enable |
| divOut | output | 1 | Divided output pulse |

## Verification
The bench targets five corner cases:
- The two worked mixed-radix examples and the extreme ratio of 15 999. A borrow chain that mishandles the split of the low nibble would show up here as a wrong period.
- The smallest ratio, 3. A zero detect placed one count too late would stretch this period to 4.
- Saturating presets. A design that did not saturate would count through illegal digit values and give a longer period.
- The timer latch. The bench checks that the output falls on the first edge after release and that the next pulse keeps its original phase, which exposes a counter that stalls while latched.
- Master preset and the fixed mode. The bench checks that master preset clears a latched output and that the fixed mode keeps a 10 000-cycle period when `jam` changes.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int DIGIT_W = 4;
  localparam int TOP_W   = DIGIT_W - 1;
  localparam logic [DIGIT_W-1:0] DEC_MAX = 4'd9;

  localparam logic [2:0] CODE_R2    = 3'b111;
  localparam logic [2:0] CODE_R4    = 3'b011;
  localparam logic [2:0] CODE_R5    = 3'b101;
  localparam logic [2:0] CODE_R8    = 3'b001;
  localparam logic [2:0] CODE_R10   = 3'b110;
  localparam logic [2:0] CODE_FIXED = 3'b000;

  typedef enum logic [2:0] {RAD2, RAD4, RAD5, RAD8, RAD10} radix_e;

  typedef struct packed {
    logic   load;
    logic   step;
    logic   fixed;
    radix_e radix;
  } strobe_t;

  function automatic logic [DIGIT_W-1:0] radixMax(radix_e r);
    case (r)
      RAD2:    return 4'd1;
      RAD4:    return 4'd3;
      RAD5:    return 4'd4;
      RAD8:    return 4'd7;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/divn_ctrl.sv
module divn_ctrl
  import divn_pkg::*;
#(
  parameter logic [2:0] C_R2    = CODE_R2,
  parameter logic [2:0] C_R4    = CODE_R4,
  parameter logic [2:0] C_R5    = CODE_R5,
  parameter logic [2:0] C_R8    = CODE_R8,
  parameter logic [2:0] C_R10   = CODE_R10,
  parameter logic [2:0] C_FIXED = CODE_FIXED
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] modeSel,
  input  logic       latchEn,
  input  logic       termOne,
  input  logic       termZero,
  output strobe_t    strobe,
  output logic       divOut
);
  logic   loadPending;
  logic   isMaster;
  logic   isFixed;
  logic   countEnd;
  logic   pulseEvt;
  radix_e radix;

  // Mode decode; every code outside the table means master preset.
  always_comb begin
    radix    = RAD10;
    isFixed  = 1'b0;
    isMaster = 1'b0;
    if      (modeSel == C_R2)    radix   = RAD2;
    else if (modeSel == C_R4)    radix   = RAD4;
    else if (modeSel == C_R5)    radix   = RAD5;
    else if (modeSel == C_R8)    radix   = RAD8;
    else if (modeSel == C_R10)   radix   = RAD10;
    else if (modeSel == C_FIXED) isFixed = 1'b1;
    else                         isMaster = 1'b1;
  end

  // Fixed mode wraps through zero; the other modes reload at count 1 (or 0).
  assign countEnd = isFixed ? termOne : (termOne | termZero);
  assign pulseEvt = ~loadPending & ~isMaster & countEnd;

  always_comb begin
    strobe.load  = loadPending | isMaster | (countEnd & ~isFixed);
    strobe.step  = ~strobe.load;
    strobe.fixed = isFixed;
    strobe.radix = radix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loadPending <= 1'b1;
      divOut      <= 1'b0;
    end else begin
      loadPending <= 1'b0;
      divOut      <= pulseEvt | (latchEn & divOut & ~isMaster);
    end
  end

  logic masterCode;
  assign masterCode = (modeSel != C_R2) && (modeSel != C_R4) && (modeSel != C_R5) &&
                      (modeSel != C_R8) && (modeSel != C_R10) && (modeSel != C_FIXED);

  // R9
  reset_low_chk: assert property (@(posedge clk) rst |=> !divOut);
  // R7
  master_low_chk: assert property (@(posedge clk) disable iff (rst) masterCode |=> !divOut);
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (divOut && latchEn && !masterCode) |=> divOut);
  // R4
  load_after_reset_chk: assert property (@(posedge clk) rst |=> strobe.load);
endmodule

// File: rtl/divn_datapath.sv
module divn_datapath
  import divn_pkg::*;
#(
  parameter int DECADES = 3,
  localparam int JAM_W  = DIGIT_W * (DECADES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [JAM_W-1:0] jam,
  input  strobe_t          strobe,
  output logic             termOne,
  output logic             termZero
);
  logic [DIGIT_W-1:0] firstQ, firstPre, firstNext, firstRaw, firstMax;
  logic [TOP_W-1:0]   topQ, topPre, topNext;
  logic [DIGIT_W-1:0] decQ [DECADES];
  logic [DECADES+1:0] borrow;
  logic               higherZero;

  assign firstMax = radixMax(strobe.radix);

  // Split of the low nibble between first stage and top stage.
  always_comb begin
    case (strobe.radix)
      RAD2:        begin firstRaw = {3'b000, jam[0]};   topPre = jam[3:1];         end
      RAD4:        begin firstRaw = {2'b00, jam[1:0]};  topPre = {1'b0, jam[3:2]}; end
      RAD5, RAD8:  begin firstRaw = {1'b0, jam[2:0]};   topPre = {2'b00, jam[3]};  end
      default:     begin firstRaw = jam[3:0];           topPre = '0;               end
    endcase
    if (strobe.fixed) topPre = '0;
    if (strobe.fixed)              firstPre = '0;
    else if (firstRaw > firstMax)  firstPre = firstMax;
    else                           firstPre = firstRaw;
  end

  assign borrow[0] = strobe.step;
  assign borrow[1] = strobe.step && (firstQ == '0);
  assign firstNext = (firstQ == '0) ? firstMax : firstQ - 1'b1;

  always_ff @(posedge clk) begin
    if (rst)              firstQ <= '0;
    else if (strobe.load) firstQ <= firstPre;
    else if (borrow[0])   firstQ <= firstNext;
  end

  for (genvar i = 0; i < DECADES; i++) begin : g_dec
    logic [DIGIT_W-1:0] rawNib, preNib;
    assign rawNib = jam[DIGIT_W*(i+1) +: DIGIT_W];
    assign preNib = strobe.fixed ? '0 : ((rawNib > DEC_MAX) ? DEC_MAX : rawNib);
    assign borrow[i+2] = borrow[i+1] && (decQ[i] == '0);

    always_ff @(posedge clk) begin
      if (rst)              decQ[i] <= '0;
      else if (strobe.load) decQ[i] <= preNib;
      else if (borrow[i+1]) decQ[i] <= (decQ[i] == '0) ? DEC_MAX : decQ[i] - 1'b1;
    end

    // R5
    decade_range_chk: assert property (@(posedge clk) disable iff (rst) decQ[i] <= DEC_MAX);
  end

  assign topNext = (strobe.radix == RAD10) ? '0 : topQ - 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                     topQ <= '0;
    else if (strobe.load)        topQ <= topPre;
    else if (borrow[DECADES+1])  topQ <= topNext;
  end

  always_comb begin
    higherZero = (topQ == '0);
    for (int i = 0; i < DECADES; i++)
      if (decQ[i] != '0) higherZero = 1'b0;
  end

  assign termOne  = higherZero && (firstQ == 4'd1);
  assign termZero = higherZero && (firstQ == '0);

  // R1
  first_range_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.load) && !$past(rst) |-> firstQ <= 4'd9);
endmodule

// File: rtl/prog_divider.sv
module prog_divider
  import divn_pkg::*;
#(
  parameter int DECADES = 3,
  localparam int JAM_W  = DIGIT_W * (DECADES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       modeSel,
  input  logic [JAM_W-1:0] jam,
  input  logic             latchEn,
  output logic             divOut
);
  strobe_t strobe;
  logic    termOne;
  logic    termZero;

  divn_ctrl u_ctrl (
    .clk(clk), .rst(rst), .modeSel(modeSel), .latchEn(latchEn),
    .termOne(termOne), .termZero(termZero), .strobe(strobe), .divOut(divOut)
  );

  divn_datapath #(.DECADES(DECADES)) u_dp (
    .clk(clk), .rst(rst), .jam(jam), .strobe(strobe),
    .termOne(termOne), .termZero(termZero)
  );
endmodule

// File: tb/tb_prog_divider.sv
module tb_prog_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  modeSel = 3'b110;
  logic [15:0] jam = 16'h0005;
  logic        latchEn = 1'b0;
  logic        divOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prog_divider dut (.clk(clk), .rst(rst), .modeSel(modeSel), .jam(jam),
                    .latchEn(latchEn), .divOut(divOut));

  // {mode, jam, expected n}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {3'b101, 16'h695C, 16'd8479},   // R1 R2 radix 5 worked example
    {3'b001, 16'h547E, 16'd12382},  // R1 R2 radix 8 worked example
    {3'b110, 16'h0123, 16'd123},    // R2 radix 10
    {3'b111, 16'h999F, 16'd15999},  // R2 largest ratio
    {3'b011, 16'h0013, 16'd7},      // R1 radix 4
    {3'b111, 16'h0011, 16'd3},      // R2 smallest ratio
    {3'b110, 16'h00FF, 16'd99},     // R5 saturation radix 10
    {3'b101, 16'h0007, 16'd4}       // R5 saturation radix 5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    @(posedge clk) #1;
    check(divOut == 1'b0, "R9 reset", divOut, 0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic waitPulse(output int cnt, input int limit);
    cnt = 0;
    do begin
      @(posedge clk) #1;
      cnt++;
    end while (!divOut && cnt < limit);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    @(posedge clk) #1;
    check(divOut == 1'b0, "R9 initial reset", divOut, 0);

    for (int v = 0; v < NV; v++) begin
      int n;
      n = int'(VEC[v][15:0]);
      @(negedge clk);
      modeSel = VEC[v][34:32];
      jam     = VEC[v][31:16];
      latchEn = 1'b0;
      doReset();
      waitPulse(c, n + 5);
      check(c == n + 1, "R4 first pulse", c, n + 1);
      @(posedge clk) #1;
      check(divOut == 1'b0, "R3 width", divOut, 0);
      waitPulse(c, n + 5);
      check(c + 1 == n, "R2 period", c + 1, n);
    end

    // R6 timer latch, n = 5
    @(negedge clk);
    modeSel = 3'b110; jam = 16'h0005; latchEn = 1'b1;
    doReset();
    waitPulse(c, 20);
    check(c == 6, "R6 first pulse", c, 6);
    c = 0;
    for (int k = 0; k < 7; k++) begin
      @(posedge clk) #1;
      if (!divOut) c++;
    end
    check(c == 0, "R6 held high", c, 0);
    @(negedge clk) latchEn = 1'b0;
    @(posedge clk) #1; check(divOut == 1'b0, "R6 release edge14", divOut, 0);
    @(posedge clk) #1; check(divOut == 1'b0, "R6 edge15", divOut, 0);
    @(posedge clk) #1; check(divOut == 1'b1, "R6 phase kept edge16", divOut, 1);
    @(posedge clk) #1; check(divOut == 1'b0, "R3 width edge17", divOut, 0);
    @(negedge clk) latchEn = 1'b1;
    waitPulse(c, 20);
    @(posedge clk) #1;
    check(divOut == 1'b1, "R6 latched again", divOut, 1);
    doReset();  // R9 clears latched output

    // R7 master preset clears latch and holds output low
    waitPulse(c, 20);
    @(negedge clk) modeSel = 3'b010;
    c = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk) #1;
      if (divOut) c++;
    end
    @(negedge clk) modeSel = 3'b100;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk) #1;
      if (divOut) c++;
    end
    check(c == 0, "R7 master low", c, 0);
    @(negedge clk) begin latchEn = 1'b0; modeSel = 3'b110; end
    waitPulse(c, 20);
    check(c == 5, "R7 restart", c, 5);

    // R8 fixed divide-by-10000 ignores jam
    @(negedge clk) begin modeSel = 3'b000; jam = 16'h1234; end
    doReset();
    waitPulse(c, 10010);
    check(c == 10001, "R8 first pulse", c, 10001);
    @(negedge clk) jam = 16'h0000;
    waitPulse(c, 10010);
    check(c == 10000, "R8 period", c, 10000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule